// File: doc/BRIEF.md
# Slow Clock Prescaler and Source Selector

This block derives a slow clock for low-power timekeeping logic from one of two sources. The first source divides the main clock by a fixed factor of two and then by a programmable 8-bit factor. The second source is an external low-speed oscillator input, nominally 32.768 kHz, sampled into the main-clock domain. After reset the divided main clock is always the source, so a slow clock exists before any software runs.

Software can request the low-speed oscillator through a select input. The request takes effect only while an activity monitor sees that input toggling, and only at an instant when both candidate sources are low, so the output never carries a shortened pulse. Once the oscillator source is in use, the prescaler stops and a permission output tells the power controller that the main oscillator may be turned off. If the low-speed input goes quiet, the selector falls back to the prescaler and withdraws that permission.

The slow clock is given both as a registered level and as a one-cycle strobe in the main-clock domain, marking each rising edge of that level. A status output reports which source drives it.

Top module: `slowclk_gen`

## Requirements
- R1: In reset and in the first cycle after it, `slow_clk`, `slow_tick`, `src_is_xtal` and `main_osc_off_ok` are all 0.
- R2: With the prescaler as source and `div_sel` = N, `slow_clk` has a period of 2×(N+1) main-clock cycles and stays high for N+1 of them (N = 0 gives 2, N = 255 gives 512).
- R3: `slow_tick` is high for exactly one main-clock cycle: the cycle in which `slow_clk` has just gone from 0 to 1.
- R4: While `xtal_req` = 1 and the low-speed input does not toggle, the prescaler remains the source, `src_is_xtal` stays 0 and the R2 period holds.
- R5: The low-speed input counts as active after at least MIN_EDGES (2) synchronized rising edges within one window of WIN_CYCLES main-clock cycles. The verdict changes only at window ends. With `xtal_req` = 0, an active input does not change the source.
- R6: With `xtal_req` = 1 and the input active, the source changes to the oscillator only in a cycle where both the divided level and the synchronized oscillator level are 0. From then on `slow_clk` has the oscillator's period.
- R7: While the oscillator is the source and is active, the prescaler is stopped and `main_osc_off_ok` = 1. Otherwise `main_osc_off_ok` = 0.
- R8: If activity is lost while the oscillator is the source, `src_is_xtal` and `main_osc_off_ok` return to 0 and the R2 period resumes.
- R9: Clearing `xtal_req` while the oscillator is the source returns the source to the prescaler at a low phase of the oscillator. The R2 period then resumes.
- R10: `src_is_xtal` is 1 exactly while the oscillator drives `slow_clk` and 0 while the prescaler does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_clk_in | input | 1 | Low-speed oscillator, asynchronous to clk_main |
| xtal_req | input | 1 | Request to use the low-speed oscillator as source |
| div_sel | input | DIV_W | Programmable divider value N, divisor 2×(N+1) |
| slow_clk | output | 1 | Registered slow clock level |
| slow_tick | output | 1 | One-cycle strobe at each rising edge of slow_clk |
| src_is_xtal | output | 1 | 1 when the low-speed oscillator is the source |
| main_osc_off_ok | output | 1 | Permission to stop the main oscillator |

## Verification
The bench builds the block with an 8-bit divider, so the table can reach both ends of the divisor range, from 2 to 512. It uses a 64-cycle activity window against a low-speed input with a 14-cycle period. This short window lets the bench see the oscillator acquired, and then lost after it is stopped, within a few hundred cycles, so the switch-over, the fallback and the release of the request all fit into a short run.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;

  // Total main-clock cycles per slow clock period for divider value n
  function automatic int unsigned calc_divisor(input int unsigned n);
    return 2 * (n + 1);
  endfunction

  // Activity verdict at a window end: edges counted so far plus one in this cycle
  function automatic bit edges_enough(input int unsigned counted,
                                      input bit          this_edge,
                                      input int unsigned min_edges);
    return (counted + (this_edge ? 1 : 0)) >= min_edges;
  endfunction

endpackage

// File: rtl/slowclk_lsync.sv
module slowclk_lsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      lvl_d  <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/slowclk_activity.sv
module slowclk_activity
  import slowclk_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 1024,
  parameter int unsigned MIN_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  output logic active,
  output logic win_end
);
  localparam int unsigned WW  = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int unsigned ECW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0]  WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [ECW-1:0] E_SAT    = ECW'(MIN_EDGES);

  logic [WW-1:0]  win_q;
  logic [ECW-1:0] ecnt_q;
  logic           active_q;

  assign win_end = (win_q == WIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      ecnt_q   <= '0;
      active_q <= 1'b0;
    end else if (win_end) begin
      win_q    <= '0;
      ecnt_q   <= '0;
      active_q <= edges_enough(int'(ecnt_q), edge_in, MIN_EDGES);
    end else begin
      win_q <= win_q + WW'(1);
      if (edge_in && ecnt_q != E_SAT)
        ecnt_q <= ecnt_q + ECW'(1);
    end
  end

  assign active = active_q;

  // R5
  verdict_at_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(active_q));
endmodule

// File: rtl/slowclk_prescale.sv
module slowclk_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             div_lvl
);
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;
  logic             half_done;

  assign half_done = (cnt_q >= div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (half_done) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign div_lvl = lvl_q;

  // R2
  half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && $stable(div_val) |-> cnt_q <= div_val);

  // R7
  stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !lvl_q && cnt_q == '0);
endmodule

// File: rtl/slowclk_gen.sv
module slowclk_gen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned WIN_CYCLES  = 1024,
  parameter int unsigned MIN_EDGES   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             ls_clk_in,
  input  logic             xtal_req,
  input  logic [DIV_W-1:0] div_sel,
  output logic             slow_clk,
  output logic             slow_tick,
  output logic             src_is_xtal,
  output logic             main_osc_off_ok
);
  logic ls_lvl, ls_rise, ls_active, win_end;
  logic div_lvl;
  logic src_q, slow_q, tick_q;
  logic go_xtal, go_back, src_next, mux_lvl;

  slowclk_lsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_main), .rst_n(rst_n), .async_in(ls_clk_in),
    .lvl(ls_lvl), .rise(ls_rise)
  );

  slowclk_activity #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_act (
    .clk(clk_main), .rst_n(rst_n), .edge_in(ls_rise),
    .active(ls_active), .win_end(win_end)
  );

  slowclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk_main), .rst_n(rst_n), .run(~src_q),
    .div_val(div_sel), .div_lvl(div_lvl)
  );

  // Switch events, brought out as named wires
  assign go_xtal  = ~src_q & xtal_req & ls_active & ~div_lvl & ~ls_lvl;
  assign go_back  = src_q & (~ls_active | (~xtal_req & ~ls_lvl));
  assign src_next = go_xtal ? 1'b1 : (go_back ? 1'b0 : src_q);
  assign mux_lvl  = src_q ? ls_lvl : div_lvl;

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      slow_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      src_q  <= src_next;
      slow_q <= mux_lvl;
      tick_q <= mux_lvl & ~slow_q;
    end
  end

  assign slow_clk        = slow_q;
  assign slow_tick       = tick_q;
  assign src_is_xtal     = src_q;
  assign main_osc_off_ok = src_q & ls_active;

  // R6
  switch_in_low_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    $rose(src_q) |-> !slow_q);

  // R9
  return_in_low_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    $fell(src_q) && $past(ls_active) |-> !slow_q);

  // R4
  no_switch_unless_ready_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    !src_q && !(xtal_req && ls_active) |=> !src_q);

  // R8
  fallback_on_loss_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    src_q && !ls_active |=> !src_q && !main_osc_off_ok);

  // R7
  prescaler_quiet_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    src_q && $past(src_q) |-> !div_lvl);

  // R3
  tick_on_rise_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    slow_tick |-> slow_clk && !$past(slow_clk));
endmodule

// File: tb/slowclk_gen_tb.sv
module slowclk_gen_tb;
  localparam int PERIOD  = 10;
  localparam int LS_HALF = 7;
  localparam int NV = 6;
  // {divider value, expected period}
  localparam int VEC [NV][2] = '{'{0, 2}, '{1, 4}, '{2, 6}, '{5, 12}, '{9, 20}, '{255, 512}};

  logic clk = 1'b0, rst_n = 1'b0, ls = 1'b0, req = 1'b0, ls_run = 1'b0;
  logic [7:0] dsel = 8'd0;
  logic slow_clk, slow_tick, src_x, off_ok;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  always begin
    if (ls_run) begin
      #(LS_HALF*PERIOD) ls = ~ls;
    end else begin
      ls = 1'b0;
      #(PERIOD);
    end
  end

  slowclk_gen #(.DIV_W(8), .WIN_CYCLES(64), .MIN_EDGES(2), .SYNC_STAGES(2)) u_dut (
    .clk_main(clk), .rst_n(rst_n), .ls_clk_in(ls), .xtal_req(req), .div_sel(dsel),
    .slow_clk(slow_clk), .slow_tick(slow_tick), .src_is_xtal(src_x), .main_osc_off_ok(off_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick_period(output int cyc, output int high);
    int n = 0;
    @(negedge clk);
    while (!slow_tick) @(negedge clk);
    high = 0;
    while (slow_clk) begin high++; @(negedge clk); end
    n = high;
    while (!slow_tick) begin n++; @(negedge clk); end
    cyc = n;
  endtask

  task automatic wait_src(input bit val, input int limit, output int got);
    int n = 0;
    while (src_x != val && n < limit) begin @(negedge clk); n++; end
    got = src_x;
  endtask

  initial begin
    int p, h, g;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!slow_clk && !slow_tick && !src_x && !off_ok, "R1 outputs in reset",
        {slow_clk, slow_tick, src_x, off_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!slow_clk && !slow_tick && !src_x && !off_ok, "R1 first cycle after reset",
        {slow_clk, slow_tick, src_x, off_ok}, 0);

    // R2 / R3 divisor table
    for (int i = 0; i < NV; i++) begin
      dsel = 8'(VEC[i][0]);
      tick_period(p, h);
      tick_period(p, h);
      chk(p == VEC[i][1], "R2 period", p, VEC[i][1]);
      chk(h == VEC[i][0] + 1, "R2 high time", h, VEC[i][0] + 1);
      chk(h < p, "R3 tick once per period", h, p);
    end

    // R3 strobe width
    dsel = 8'd3;
    @(negedge clk);
    while (!slow_tick) @(negedge clk);
    @(negedge clk);
    chk(!slow_tick && slow_clk, "R3 strobe one cycle", slow_tick, 0);

    // R4 request without oscillator activity
    req = 1'b1;
    repeat (300) @(negedge clk);
    chk(!src_x && !off_ok, "R4 stays on prescaler", src_x, 0);
    tick_period(p, h);
    chk(p == 8, "R4 period kept", p, 8);

    // R5 activity without request changes nothing
    req = 1'b0;
    ls_run = 1'b1;
    repeat (300) @(negedge clk);
    chk(!src_x && !off_ok, "R5 active but not requested", src_x, 0);

    // R6 / R7 / R10 switch to oscillator
    req = 1'b1;
    wait_src(1'b1, 400, g);
    chk(g == 1, "R6 switched to oscillator", g, 1);
    chk(off_ok, "R7 main-off permission", off_ok, 1);
    tick_period(p, h);
    tick_period(p, h);
    chk(p == 2*LS_HALF, "R6 oscillator period", p, 2*LS_HALF);
    chk(h == LS_HALF, "R10 follows oscillator", h, LS_HALF);

    // R8 loss of activity
    ls_run = 1'b0;
    wait_src(1'b0, 300, g);
    chk(g == 0, "R8 fallback to prescaler", g, 0);
    chk(!off_ok, "R8 permission withdrawn", off_ok, 0);
    tick_period(p, h);
    tick_period(p, h);
    chk(p == 8, "R8 prescaler period resumes", p, 8);

    // R9 request cleared while oscillator active
    ls_run = 1'b1;
    wait_src(1'b1, 400, g);
    chk(g == 1, "R9 reacquired oscillator", g, 1);
    req = 1'b0;
    wait_src(1'b0, 40, g);
    chk(g == 0, "R9 returned on clear", g, 0);
    chk(!off_ok, "R9 permission cleared", off_ok, 0);
    tick_period(p, h);
    tick_period(p, h);
    chk(p == 8, "R9 prescaler period", p, 8);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule